// File: doc/BRIEF.md
# Host Bus Register-Space Decoder

The block sits between a 16-bit host bus and the on-chip storage of a media subsystem. Each host access carries an address, a read/write flag, a byte/word size flag and 16 bits of write data. The block picks exactly one target for the access, turns the host address into that target's word index, shapes the write data and lane enables, and returns registered read data one clock later. Addresses inside the I/O window reach control registers, a colour lookup table, three line buffers and two processor-local RAMs built from 32-bit words. Reads outside the window come from a boot ROM. Writes outside the window are dropped.

The two local RAMs take 32-bit words, but the host writes only 16 bits at a time. The block sends the 16-bit value on both halves of the 32-bit write bus and raises one half-enable, so the RAM changes one half of the word and keeps the other. A byte write is widened by copying the byte into both lanes. A byte read returns the addressed lane. Reads with no backing storage return all ones.

All target ports share one select code, one index, one write bus and one 32-bit read-return bus. The surrounding logic demultiplexes them by the select code. Every target is assumed to answer a read in the same cycle as the request.

Top module: `hostBusDecoder`

## Requirements
- R1: An access whose address is below 0x100000 or above 0x11FFFF counts as outside the window. A read there selects the boot ROM (select code 1) with word index address[15:1]. A write there raises no write strobe.
- R2: Inside the window the select code is chosen by address range: 0x100000-0x1003FF control registers (2), 0x100400-0x1007FF colour table (3), 0x100800-0x100FFF line buffer A (4), 0x101000-0x1017FF line buffer B (5), 0x101800-0x1020FF write line buffer (6), 0x103000-0x10FFFF first local RAM (7), 0x11B000-0x11CFFF second local RAM (8). Any other address in the window selects nothing (0).
- R3: The control registers use index address[9:1]. The colour table uses index address[8:1], so address bit 9 is ignored and the table repeats every 512 bytes.
- R4: The line buffers use index address[10:1]. With an index at or above LINE_DEPTH (default 720), a write is dropped and a read returns 0xFFFF.
- R5: The first local RAM uses word index address[11:2] and the second uses address[12:2]. A word write to either puts the 16-bit value on both halves of the 32-bit write bus. It raises half-enable bit 0 (low half, bits 15:0) when address bit 1 is 1, and half-enable bit 1 (high half, bits 31:16) when it is 0. The other half of the word is preserved.
- R6: A word read from a local RAM returns bits 15:0 of the word when address bit 1 is 1, and bits 31:16 when it is 0. A word read from any other target returns bits 15:0 of the read-return bus.
- R7: A byte write (hostByte=1) replaces the write data with {data[7:0], data[7:0]} before it reaches any target.
- R8: A byte read returns, in hostRdData[7:0] with bits 15:8 zero, the low byte of the addressed 16-bit value when address bit 0 is 1, and the high byte when it is 0.
- R9: A word read that selects nothing returns 0xFFFF.
- R10: Read data and hostRdValid update on the clock edge that ends the request cycle. hostRdValid is high for exactly one cycle per read request. After reset hostRdValid and hostRdData are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostReq | input | 1 | Host access request, one cycle per access |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostByte | input | 1 | 1 = byte access, 0 = 16-bit access |
| hostAddr | input | ADDR_W (24) | Host byte address |
| hostWrData | input | 16 | Host write data |
| hostRdData | output | 16 | Registered read data |
| hostRdValid | output | 1 | Read data valid pulse |
| tgtSel | output | 4 | Selected target code |
| tgtIndex | output | IDXW (16) | Word index in the selected target |
| tgtWe | output | 1 | Target write strobe |
| tgtRe | output | 1 | Target read strobe |
| tgtHalfEn | output | 2 | Half enables: bit 1 = bits 31:16, bit 0 = bits 15:0 |
| tgtWrData | output | 32 | Target write data |
| tgtRdData | input | 32 | Read-return data from the selected target, same cycle |

## Verification
A wrong range boundary or index slice makes the write land in the wrong cell. That error only shows at the ports on a later read of that address, which returns a stale value or a neighbour's value. A wrong half-enable or lane choice damages the preserved half of a local-RAM word. The next read of the other half then returns the new value where it should return the old one. Errors in the read path show up one cycle after the request, as a wrong value or a wrong valid pulse.

// File: rtl/hostDecPkg.sv
package hostDecPkg;

  typedef enum logic [3:0] {
    TGT_NONE = 4'd0,
    TGT_ROM  = 4'd1,
    TGT_CTRL = 4'd2,
    TGT_CLUT = 4'd3,
    TGT_LBA  = 4'd4,
    TGT_LBB  = 4'd5,
    TGT_LBW  = 4'd6,
    TGT_GPU  = 4'd7,
    TGT_DSP  = 4'd8
  } tgt_e;

  // strobes from the decode control to the datapath
  typedef struct packed {
    tgt_e sel;
    logic wrEn;
    logic rdEn;
    logic rdCapture;
    logic isByte;
    logic lowHalf;
    logic lowByte;
  } strobe_t;

  // range boundaries (byte addresses, upper bound exclusive)
  localparam logic [23:0] WIN_LO   = 24'h100000;
  localparam logic [23:0] WIN_END  = 24'h120000;
  localparam logic [23:0] CLUT_LO  = 24'h100400;
  localparam logic [23:0] LBA_LO   = 24'h100800;
  localparam logic [23:0] LBB_LO   = 24'h101000;
  localparam logic [23:0] LBW_LO   = 24'h101800;
  localparam logic [23:0] GAP_LO   = 24'h102100;
  localparam logic [23:0] GPU_LO   = 24'h103000;
  localparam logic [23:0] GPU_END  = 24'h110000;
  localparam logic [23:0] DSP_LO   = 24'h11B000;
  localparam logic [23:0] DSP_END  = 24'h11D000;

endpackage

// File: rtl/hostDecodeCtl.sv
module hostDecodeCtl
  import hostDecPkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int IDXW       = 16,
  parameter int ROM_WORDS  = 32768,
  parameter int GPU_WORDS  = 1024,
  parameter int DSP_WORDS  = 2048,
  parameter int LINE_DEPTH = 720
) (
  input  logic              hostReq,
  input  logic              hostWrite,
  input  logic              hostByte,
  input  logic [ADDR_W-1:0] hostAddr,
  output strobe_t           strb,
  output logic [IDXW-1:0]   index
);

  localparam int ROM_AW = $clog2(ROM_WORDS);
  localparam int GPU_AW = $clog2(GPU_WORDS);
  localparam int DSP_AW = $clog2(DSP_WORDS);

  logic [23:0] addr;
  logic [9:0]  lineIdx;
  tgt_e        rangeSel;
  tgt_e        finalSel;
  logic        isLine;

  assign addr    = 24'(hostAddr);
  assign lineIdx = hostAddr[10:1];

  // coarse range decode
  always_comb begin
    if (addr < WIN_LO || addr >= WIN_END) rangeSel = hostWrite ? TGT_NONE : TGT_ROM;
    else if (addr < CLUT_LO)              rangeSel = TGT_CTRL;
    else if (addr < LBA_LO)               rangeSel = TGT_CLUT;
    else if (addr < LBB_LO)               rangeSel = TGT_LBA;
    else if (addr < LBW_LO)               rangeSel = TGT_LBB;
    else if (addr < GAP_LO)               rangeSel = TGT_LBW;
    else if (addr < GPU_LO)               rangeSel = TGT_NONE;
    else if (addr < GPU_END)              rangeSel = TGT_GPU;
    else if (addr < DSP_LO)               rangeSel = TGT_NONE;
    else if (addr < DSP_END)              rangeSel = TGT_DSP;
    else                                  rangeSel = TGT_NONE;
  end

  // line buffer depth guard
  assign isLine   = (rangeSel == TGT_LBA) || (rangeSel == TGT_LBB) || (rangeSel == TGT_LBW);
  assign finalSel = (isLine && (32'(lineIdx) >= LINE_DEPTH)) ? TGT_NONE : rangeSel;

  // per-target word index
  always_comb begin
    unique case (finalSel)
      TGT_ROM:  index = IDXW'(hostAddr[ROM_AW:1]);
      TGT_CTRL: index = IDXW'(hostAddr[9:1]);
      TGT_CLUT: index = IDXW'(hostAddr[8:1]);
      TGT_LBA,
      TGT_LBB,
      TGT_LBW:  index = IDXW'(lineIdx);
      TGT_GPU:  index = IDXW'(hostAddr[GPU_AW+1:2]);
      TGT_DSP:  index = IDXW'(hostAddr[DSP_AW+1:2]);
      default:  index = '0;
    endcase
  end

  always_comb begin
    strb.sel       = finalSel;
    strb.wrEn      = hostReq && hostWrite && (finalSel != TGT_NONE);
    strb.rdEn      = hostReq && !hostWrite && (finalSel != TGT_NONE);
    strb.rdCapture = hostReq && !hostWrite;
    strb.isByte    = hostByte;
    strb.lowHalf   = hostAddr[1];
    strb.lowByte   = hostAddr[0];
  end

endmodule

// File: rtl/hostDataPath.sv
module hostDataPath
  import hostDecPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  strobe_t     strb,
  input  logic [15:0] hostWrData,
  input  logic [31:0] tgtRdData,
  output logic        tgtWe,
  output logic        tgtRe,
  output logic [1:0]  tgtHalfEn,
  output logic [31:0] tgtWrData,
  output logic [15:0] hostRdData,
  output logic        hostRdValid
);

  logic        isLocal;
  logic [15:0] wordIn;
  logic [15:0] wordOut;
  logic [7:0]  byteOut;
  logic [15:0] rdNext;

  assign isLocal = (strb.sel == TGT_GPU) || (strb.sel == TGT_DSP);

  // write shaping: lane copy for bytes, half copy for 32-bit words
  assign wordIn    = strb.isByte ? {hostWrData[7:0], hostWrData[7:0]} : hostWrData;
  assign tgtWrData = isLocal ? {wordIn, wordIn} : {16'h0000, wordIn};
  assign tgtHalfEn = isLocal ? (strb.lowHalf ? 2'b01 : 2'b10) : 2'b01;
  assign tgtWe     = strb.wrEn;
  assign tgtRe     = strb.rdEn;

  // read steering
  always_comb begin
    if (strb.sel == TGT_NONE) wordOut = 16'hFFFF;
    else if (isLocal)         wordOut = strb.lowHalf ? tgtRdData[15:0] : tgtRdData[31:16];
    else                      wordOut = tgtRdData[15:0];
    byteOut = strb.lowByte ? wordOut[7:0] : wordOut[15:8];
    rdNext  = strb.isByte ? {8'h00, byteOut} : wordOut;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hostRdData  <= '0;
      hostRdValid <= 1'b0;
    end else begin
      hostRdValid <= strb.rdCapture;
      if (strb.rdCapture) hostRdData <= rdNext;
    end
  end

endmodule

// File: rtl/hostBusDecoder.sv
module hostBusDecoder
  import hostDecPkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int IDXW       = 16,
  parameter int ROM_WORDS  = 32768,
  parameter int GPU_WORDS  = 1024,
  parameter int DSP_WORDS  = 2048,
  parameter int LINE_DEPTH = 720
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostReq,
  input  logic              hostWrite,
  input  logic              hostByte,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [15:0]       hostWrData,
  output logic [15:0]       hostRdData,
  output logic              hostRdValid,
  output logic [3:0]        tgtSel,
  output logic [IDXW-1:0]   tgtIndex,
  output logic              tgtWe,
  output logic              tgtRe,
  output logic [1:0]        tgtHalfEn,
  output logic [31:0]       tgtWrData,
  input  logic [31:0]       tgtRdData
);

  strobe_t strb;

  hostDecodeCtl #(
    .ADDR_W(ADDR_W), .IDXW(IDXW), .ROM_WORDS(ROM_WORDS),
    .GPU_WORDS(GPU_WORDS), .DSP_WORDS(DSP_WORDS), .LINE_DEPTH(LINE_DEPTH)
  ) uCtl (
    .hostReq(hostReq), .hostWrite(hostWrite), .hostByte(hostByte),
    .hostAddr(hostAddr), .strb(strb), .index(tgtIndex)
  );

  hostDataPath uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .hostWrData(hostWrData),
    .tgtRdData(tgtRdData), .tgtWe(tgtWe), .tgtRe(tgtRe),
    .tgtHalfEn(tgtHalfEn), .tgtWrData(tgtWrData),
    .hostRdData(hostRdData), .hostRdValid(hostRdValid)
  );

  assign tgtSel = strb.sel;

endmodule

// File: rtl/hostBusDecoderChk.sv
module hostBusDecoderChk
  import hostDecPkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int IDXW       = 16,
  parameter int LINE_DEPTH = 720
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostReq,
  input logic              hostWrite,
  input logic              hostByte,
  input logic [ADDR_W-1:0] hostAddr,
  input logic [15:0]       hostRdData,
  input logic              hostRdValid,
  input logic [3:0]        tgtSel,
  input logic [IDXW-1:0]   tgtIndex,
  input logic              tgtWe,
  input logic              tgtRe,
  input logic [1:0]        tgtHalfEn,
  input logic [31:0]       tgtWrData
);

  logic outside;
  logic isLocalSel;
  logic isLineSel;
  assign outside    = (24'(hostAddr) < WIN_LO) || (24'(hostAddr) >= WIN_END);
  assign isLocalSel = (tgtSel == TGT_GPU) || (tgtSel == TGT_DSP);
  assign isLineSel  = (tgtSel == TGT_LBA) || (tgtSel == TGT_LBB) || (tgtSel == TGT_LBW);

  assert_outside_write_R1: assert property (@(posedge clk) disable iff (!rstN)
    hostReq && hostWrite && outside |-> !tgtWe);

  assert_outside_read_R1: assert property (@(posedge clk) disable iff (!rstN)
    hostReq && !hostWrite && outside |-> (tgtSel == TGT_ROM) && tgtRe);

  assert_line_depth_R4: assert property (@(posedge clk) disable iff (!rstN)
    isLineSel && (tgtWe || tgtRe) |-> (32'(tgtIndex) < LINE_DEPTH));

  assert_half_enable_R5: assert property (@(posedge clk) disable iff (!rstN)
    tgtWe && isLocalSel |-> ($countones(tgtHalfEn) == 1) && (tgtHalfEn[0] == hostAddr[1])
                            && (tgtWrData[31:16] == tgtWrData[15:0]));

  assert_byte_copy_R7: assert property (@(posedge clk) disable iff (!rstN)
    tgtWe && hostByte |-> tgtWrData[7:0] == tgtWrData[15:8]);

  assert_byte_upper_R8: assert property (@(posedge clk) disable iff (!rstN)
    hostReq && !hostWrite && hostByte |=> hostRdData[15:8] == 8'h00);

  assert_unmapped_R9: assert property (@(posedge clk) disable iff (!rstN)
    hostReq && !hostWrite && !hostByte && (tgtSel == TGT_NONE) |=> hostRdData == 16'hFFFF);

  assert_valid_rise_R10: assert property (@(posedge clk) disable iff (!rstN)
    hostReq && !hostWrite |=> hostRdValid);

  assert_valid_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(hostReq && !hostWrite) |=> !hostRdValid);

  assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (!rstN)
    (tgtWe || tgtRe) |-> !(tgtWe && tgtRe) && (tgtSel != TGT_NONE));

endmodule

bind hostBusDecoder hostBusDecoderChk #(
  .ADDR_W(ADDR_W), .IDXW(IDXW), .LINE_DEPTH(LINE_DEPTH)
) uChk (
  .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostWrite(hostWrite),
  .hostByte(hostByte), .hostAddr(hostAddr), .hostRdData(hostRdData),
  .hostRdValid(hostRdValid), .tgtSel(tgtSel), .tgtIndex(tgtIndex),
  .tgtWe(tgtWe), .tgtRe(tgtRe), .tgtHalfEn(tgtHalfEn), .tgtWrData(tgtWrData)
);

// File: tb/tb_hostBusDecoder.sv
module tb_hostBusDecoder;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostReq = 1'b0;
  logic        hostWrite = 1'b0;
  logic        hostByte = 1'b0;
  logic [23:0] hostAddr = '0;
  logic [15:0] hostWrData = '0;
  logic [15:0] hostRdData;
  logic        hostRdValid;
  logic [3:0]  tgtSel;
  logic [15:0] tgtIndex;
  logic        tgtWe;
  logic        tgtRe;
  logic [1:0]  tgtHalfEn;
  logic [31:0] tgtWrData;
  logic [31:0] tgtRdData;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  hostBusDecoder dut (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostWrite(hostWrite),
    .hostByte(hostByte), .hostAddr(hostAddr), .hostWrData(hostWrData),
    .hostRdData(hostRdData), .hostRdValid(hostRdValid), .tgtSel(tgtSel),
    .tgtIndex(tgtIndex), .tgtWe(tgtWe), .tgtRe(tgtRe), .tgtHalfEn(tgtHalfEn),
    .tgtWrData(tgtWrData), .tgtRdData(tgtRdData)
  );

  // ---------------- target storage driven by the DUT ----------------
  logic [15:0] ctrlMem [512];
  logic [15:0] clutMem [256];
  logic [15:0] lbMem   [3][1024];
  logic [31:0] gpuMem  [1024];
  logic [31:0] dspMem  [2048];

  function automatic logic [15:0] romWord(input logic [14:0] i);
    return {i[6:0], i[14:6]} ^ 16'hC35A;
  endfunction

  always_comb begin
    case (tgtSel)
      4'd1: tgtRdData = {16'hDEAD, romWord(tgtIndex[14:0])};
      4'd2: tgtRdData = {16'hDEAD, ctrlMem[tgtIndex[8:0]]};
      4'd3: tgtRdData = {16'hDEAD, clutMem[tgtIndex[7:0]]};
      4'd4: tgtRdData = {16'hDEAD, lbMem[0][tgtIndex[9:0]]};
      4'd5: tgtRdData = {16'hDEAD, lbMem[1][tgtIndex[9:0]]};
      4'd6: tgtRdData = {16'hDEAD, lbMem[2][tgtIndex[9:0]]};
      4'd7: tgtRdData = gpuMem[tgtIndex[9:0]];
      4'd8: tgtRdData = dspMem[tgtIndex[10:0]];
      default: tgtRdData = 32'h1234_5678;
    endcase
  end

  always @(posedge clk) begin
    if (tgtWe) begin
      case (tgtSel)
        4'd2: ctrlMem[tgtIndex[8:0]] <= tgtWrData[15:0];
        4'd3: clutMem[tgtIndex[7:0]] <= tgtWrData[15:0];
        4'd4: lbMem[0][tgtIndex[9:0]] <= tgtWrData[15:0];
        4'd5: lbMem[1][tgtIndex[9:0]] <= tgtWrData[15:0];
        4'd6: lbMem[2][tgtIndex[9:0]] <= tgtWrData[15:0];
        4'd7: begin
          if (tgtHalfEn[1]) gpuMem[tgtIndex[9:0]][31:16] <= tgtWrData[31:16];
          if (tgtHalfEn[0]) gpuMem[tgtIndex[9:0]][15:0]  <= tgtWrData[15:0];
        end
        4'd8: begin
          if (tgtHalfEn[1]) dspMem[tgtIndex[10:0]][31:16] <= tgtWrData[31:16];
          if (tgtHalfEn[0]) dspMem[tgtIndex[10:0]][15:0]  <= tgtWrData[15:0];
        end
        default: ;
      endcase
    end
  end

  // ---------------- reference model keyed by host address ----------------
  logic [15:0] refCtrl [512];
  logic [15:0] refClut [256];
  logic [15:0] refLb   [3][1024];
  logic [31:0] refGpu  [1024];
  logic [31:0] refDsp  [2048];

  // 0 none, 1 rom, 2 ctrl, 3 clut, 4..6 line buffers, 7 first local, 8 second local
  function automatic int kindOf(input logic [23:0] a, input logic w);
    int k;
    if (a < 24'h100000 || a > 24'h11FFFF) return w ? 0 : 1;
    if (a < 24'h100400) k = 2;
    else if (a < 24'h100800) k = 3;
    else if (a < 24'h101000) k = 4;
    else if (a < 24'h101800) k = 5;
    else if (a < 24'h102100) k = 6;
    else if (a < 24'h103000) k = 0;
    else if (a < 24'h110000) k = 7;
    else if (a < 24'h11B000) k = 0;
    else if (a < 24'h11D000) k = 8;
    else k = 0;
    if (k >= 4 && k <= 6 && int'(a[10:1]) >= 720) k = 0;
    return k;
  endfunction

  function automatic string tagOf(input int k, input logic b, input logic w);
    if (b) return w ? "R7" : "R8";
    case (k)
      0: return "R9";
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4, 5, 6: return "R4";
      default: return w ? "R5" : "R6";
    endcase
  endfunction

  function automatic logic [15:0] refRead(input logic [23:0] a, input logic b);
    logic [15:0] wd;
    case (kindOf(a, 1'b0))
      1: wd = romWord(a[15:1]);
      2: wd = refCtrl[a[9:1]];
      3: wd = refClut[a[8:1]];
      4: wd = refLb[0][a[10:1]];
      5: wd = refLb[1][a[10:1]];
      6: wd = refLb[2][a[10:1]];
      7: wd = a[1] ? refGpu[a[11:2]][15:0] : refGpu[a[11:2]][31:16];
      8: wd = a[1] ? refDsp[a[12:2]][15:0] : refDsp[a[12:2]][31:16];
      default: wd = 16'hFFFF;
    endcase
    if (b) return {8'h00, a[0] ? wd[7:0] : wd[15:8]};
    return wd;
  endfunction

  task automatic refWrite(input logic [23:0] a, input logic [15:0] d, input logic b);
    logic [15:0] wd;
    wd = b ? {d[7:0], d[7:0]} : d;
    case (kindOf(a, 1'b1))
      2: refCtrl[a[9:1]] = wd;
      3: refClut[a[8:1]] = wd;
      4: refLb[0][a[10:1]] = wd;
      5: refLb[1][a[10:1]] = wd;
      6: refLb[2][a[10:1]] = wd;
      7: if (a[1]) refGpu[a[11:2]][15:0] = wd; else refGpu[a[11:2]][31:16] = wd;
      8: if (a[1]) refDsp[a[12:2]][15:0] = wd; else refDsp[a[12:2]][31:16] = wd;
      default: ;
    endcase
  endtask

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one host access: drive at a falling edge, result after the next rising edge
  task automatic doAccess(input logic w, input logic b, input logic [23:0] a, input logic [15:0] d);
    int k;
    logic [15:0] expv;
    k = kindOf(a, w);
    expv = refRead(a, b);
    @(negedge clk);
    hostReq = 1'b1; hostWrite = w; hostByte = b; hostAddr = a; hostWrData = d;
    #1;
    if (w && k == 0) check(tgtWe == 1'b0, tagOf(k, b, w), {31'd0, tgtWe}, 32'd0);
    @(negedge clk);
    hostReq = 1'b0; hostWrite = 1'b0; hostByte = 1'b0;
    if (w) refWrite(a, d, b);
    else begin
      check(hostRdValid == 1'b1, "R10", {31'd0, hostRdValid}, 32'd1);
      check(hostRdData == expv, tagOf(k, b, w), {16'd0, hostRdData}, {16'd0, expv});
    end
  endtask

  task automatic readExpect(input logic b, input logic [23:0] a, input logic [15:0] e, input string tag);
    @(negedge clk);
    hostReq = 1'b1; hostWrite = 1'b0; hostByte = b; hostAddr = a;
    @(negedge clk);
    hostReq = 1'b0; hostByte = 1'b0;
    check(hostRdData == e, tag, {16'd0, hostRdData}, {16'd0, e});
  endtask

  logic [23:0] bases [10];

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 512; i++) begin ctrlMem[i] = '0; refCtrl[i] = '0; end
    for (int i = 0; i < 256; i++) begin clutMem[i] = '0; refClut[i] = '0; end
    for (int j = 0; j < 3; j++)
      for (int i = 0; i < 1024; i++) begin lbMem[j][i] = '0; refLb[j][i] = '0; end
    for (int i = 0; i < 1024; i++) begin gpuMem[i] = '0; refGpu[i] = '0; end
    for (int i = 0; i < 2048; i++) begin dspMem[i] = '0; refDsp[i] = '0; end
    bases = '{24'h000100, 24'h100020, 24'h100500, 24'h100840, 24'h101100,
              24'h101900, 24'h103040, 24'h11B080, 24'h102400, 24'h11E000};

    repeat (3) @(posedge clk);
    @(negedge clk);
    // reset state (R10)
    check(hostRdValid == 1'b0, "R10", {31'd0, hostRdValid}, 32'd0);
    check(hostRdData == 16'h0000, "R10", {16'd0, hostRdData}, 32'd0);
    rstN = 1'b1;

    // R2/R3: control register write then read
    doAccess(1'b1, 1'b0, 24'h100006, 16'hBEEF);
    doAccess(1'b0, 1'b0, 24'h100006, 16'h0);
    // R3: colour table ignores address bit 9
    doAccess(1'b1, 1'b0, 24'h100402, 16'h1357);
    readExpect(1'b0, 24'h100602, 16'h1357, "R3");
    // R4: line buffer in range, then beyond depth
    doAccess(1'b1, 1'b0, 24'h101000 + 24'd2 * 24'd719, 16'h4444);
    doAccess(1'b0, 1'b0, 24'h101000 + 24'd2 * 24'd719, 16'h0);
    doAccess(1'b1, 1'b0, 24'h100800 + 24'd2 * 24'd800, 16'h7777);
    readExpect(1'b0, 24'h100800 + 24'd2 * 24'd800, 16'hFFFF, "R4");
    // R5/R6: half merge in the first local RAM, plus index mirror
    doAccess(1'b1, 1'b0, 24'h103010, 16'h1234);
    doAccess(1'b1, 1'b0, 24'h103012, 16'hABCD);
    readExpect(1'b0, 24'h103010, 16'h1234, "R5");
    readExpect(1'b0, 24'h103012, 16'hABCD, "R6");
    readExpect(1'b0, 24'h104012, 16'hABCD, "R5");
    // second local RAM, low half only, high half stays zero
    doAccess(1'b1, 1'b0, 24'h11C002, 16'h5A5A);
    readExpect(1'b0, 24'h11C000, 16'h0000, "R5");
    readExpect(1'b0, 24'h11C002, 16'h5A5A, "R6");
    // R7: byte write copies into both lanes
    doAccess(1'b1, 1'b1, 24'h100011, 16'hFF3C);
    readExpect(1'b0, 24'h100010, 16'h3C3C, "R7");
    // R8: byte reads pick the lane by bit 0
    readExpect(1'b1, 24'h103010, 16'h0012, "R8");
    readExpect(1'b1, 24'h103011, 16'h0034, "R8");
    // R1: outside writes ignored, reads from ROM
    doAccess(1'b1, 1'b0, 24'h000010, 16'h9999);
    readExpect(1'b0, 24'h000010, romWord(15'h0008), "R1");
    readExpect(1'b0, 24'h120004, romWord(15'h0002), "R1");
    // R9: unmapped ranges
    readExpect(1'b0, 24'h102500, 16'hFFFF, "R9");
    readExpect(1'b0, 24'h118000, 16'hFFFF, "R9");
    readExpect(1'b0, 24'h11E000, 16'hFFFF, "R9");
    // R10: valid is a single-cycle pulse
    @(negedge clk);
    check(hostRdValid == 1'b0, "R10", {31'd0, hostRdValid}, 32'd0);

    // constrained random mix
    for (int n = 0; n < 600; n++) begin
      logic [23:0] a;
      a = bases[$urandom_range(0, 9)] + 24'($urandom_range(0, 63));
      doAccess(1'($urandom_range(0, 1)), ($urandom_range(0, 3) == 0),
               a, 16'($urandom()));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule